// File: doc/BRIEF.md
# Threshold-Backtracking Sequential Decoder

This block decodes one frame of a rate-half convolutional code with eight states. Its two generators are 1111 and 1101. The decoder works on hard decisions. The user first writes the received two-bit symbols into an internal buffer, one symbol per cycle. A frame holds up to 16 symbols, and the last three of them are the tail that returns the encoder to the zero state. A start pulse then launches a depth-first search of the code tree.

At each tree node the decoder weighs the two branch codewords against the received pair and extends along the closer one. It keeps a running count of mismatches along the path. A branch is only taken if it keeps that count under a threshold of three. When a node has no usable branch left, the decoder steps back one level. It keeps stepping back until it reaches a level that still has an untried branch. The decoder either reaches the end of the frame and raises `done` with the data bits, or it runs out of options at the root and raises `fail`. Each extension or backward step costs one clock cycle.

Top module: `sd_seq_decoder`

## Requirements
- R1: The encoder model starts in state 000. For input u in state (s1,s2,s3), where s1 is the most recent bit, the symbol is {v1,v2} with v1 = u^s1^s2^s3 and v2 = u^s1^s3. v1 travels on `sym_bits[1]` and v2 on `sym_bits[0]`. The next state is (u,s1,s2).
- R2: At each node the branch whose codeword has the smaller Hamming distance to the received pair is tried first. On a tie, input 0 is tried first.
- R3: A branch is extended only if the mismatch tally after it stays below 3. The tally stored for the current level is therefore always below 3.
- R4: A level with no untried usable branch is left by one backward step. The search then takes the remaining branch of the nearest earlier level that still has one.
- R5: In the last three levels of a frame, only input 0 may be taken.
- R6: If the root has no branch left, `fail` is raised and `done` stays low. `done` and `fail` are never high together. Both flags hold until the next accepted start.
- R7: On success, `data_out` bit i holds the i-th decoded data bit, with bit 0 decoded first. `data_len` equals the symbol count minus 3, and the tail bits appear as zeros above `data_len`. Before success, `data_out` and `data_len` are zero.
- R8: The received frame 01 11 01 11 01 01 11 decodes to data 1011 in exactly 20 search cycles.
- R9: A start with 3 or fewer buffered symbols raises `fail` on the next clock edge. Symbols offered after the 16th are ignored.
- R10: Each search cycle makes one step, so the depth changes by at most one per cycle. An error-free frame of L symbols finishes in L cycles.
- R11: Symbols and start pulses offered while `busy` is high are ignored. Each accepted start empties the buffer for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Appends `sym_bits` to the frame buffer |
| sym_bits | input | 2 | Received pair, {v1,v2} |
| start | input | 1 | Begins decoding the buffered frame |
| busy | output | 1 | Search in progress |
| done | output | 1 | Frame decoded |
| fail | output | 1 | Search exhausted or frame too short |
| data_out | output | 13 | Decoded data bits, first bit at bit 0 |
| data_len | output | 4 | Number of valid data bits |

## Verification
The embedded assertions check four properties on every cycle:
- the stored tally of the current level stays under the threshold;
- the depth moves by at most one level per cycle;
- the root level sits in the zero state, and tail levels carry only input-0 decisions;
- `done` and `fail` are never high together.

Whether the search reaches the right answer can only be shown by the bench scenarios. These cover the tie-breaking order, the exact backtracking path and cycle count on the known errored frame, clean frames checked against an independent encoder, exhausted searches, and a tail-restricted frame that would succeed without the input-0 rule. They also cover inputs that must be ignored.

// File: rtl/sd_pkg.sv
package sd_pkg;

    typedef enum logic {
        SD_IDLE   = 1'b0,
        SD_SEARCH = 1'b1
    } sd_mode_e;

    // state[2] = most recent bit, state[0] = oldest bit
    function automatic logic [1:0] sd_codeword(input logic [2:0] st, input logic u);
        logic v1, v2;
        v1 = u ^ st[2] ^ st[1] ^ st[0];
        v2 = u ^ st[2] ^ st[0];
        return {v1, v2};
    endfunction

    function automatic logic [2:0] sd_next_state(input logic [2:0] st, input logic u);
        return {u, st[2:1]};
    endfunction

    function automatic logic [1:0] sd_ham2(input logic [1:0] a, input logic [1:0] b);
        logic [1:0] x;
        x = a ^ b;
        return {1'b0, x[1]} + {1'b0, x[0]};
    endfunction

endpackage

// File: rtl/sd_symbol_buf.sv
module sd_symbol_buf #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_data,
    input  logic          clr,
    input  logic [AW-1:0] rd_idx,
    output logic [1:0]    rd_data,
    output logic [AW-1:0] count
);
    localparam int SLOTS = 1 << AW;

    logic [1:0] mem_q [SLOTS];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (wr_en && (count < AW'(DEPTH))) begin
            mem_q[count] <= wr_data;
            count        <= count + AW'(1);
        end
    end

    assign rd_data = mem_q[rd_idx];

    always @(posedge clk) begin
        assert_count_bound_R9: assert (rst || count <= AW'(DEPTH))
            else $error("buffer count above capacity");
    end
endmodule

// File: rtl/sd_branch_unit.sv
module sd_branch_unit
    import sd_pkg::*;
(
    input  logic [2:0] cur_state,
    input  logic [1:0] rx_pair,
    input  logic [1:0] tried,
    input  logic       tail_only,
    output logic       avail,
    output logic       choice,
    output logic [1:0] metric
);
    logic [1:0] m0, m1;
    logic       pref, ok0, ok1, ok_pref, ok_other;

    always_comb begin
        m0       = sd_ham2(rx_pair, sd_codeword(cur_state, 1'b0));
        m1       = sd_ham2(rx_pair, sd_codeword(cur_state, 1'b1));
        pref     = (m1 < m0);
        ok0      = ~tried[0];
        ok1      = ~tried[1] & ~tail_only;
        ok_pref  = pref ? ok1 : ok0;
        ok_other = pref ? ok0 : ok1;
        avail    = ok0 | ok1;
        choice   = ok_pref ? pref : ~pref;
        if (!ok_pref && !ok_other) choice = 1'b0;
        metric   = choice ? m1 : m0;
    end
endmodule

// File: rtl/sd_seq_decoder.sv
module sd_seq_decoder
    import sd_pkg::*;
#(
    parameter int MAX_SYM = 16,
    parameter int TAIL    = 3,
    parameter int THR     = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         sym_valid,
    input  logic [1:0]                   sym_bits,
    input  logic                         start,
    output logic                         busy,
    output logic                         done,
    output logic                         fail,
    output logic [MAX_SYM-TAIL-1:0]      data_out,
    output logic [$clog2(MAX_SYM-TAIL+1)-1:0] data_len
);
    localparam int DW    = $clog2(MAX_SYM + 1);
    localparam int SLOTS = 1 << DW;
    localparam int MAXD  = MAX_SYM - TAIL;
    localparam int LW    = $clog2(MAXD + 1);
    localparam int TW    = $clog2(THR + 2);

    sd_mode_e          mode_q;
    logic [DW-1:0]     depth_q, len_q, buf_cnt, depth_nx;
    logic [2:0]        st_q    [SLOTS];
    logic [TW-1:0]     tal_q   [SLOTS];
    logic [1:0]        tried_q [SLOTS];
    logic [SLOTS-1:0]  dec_q;
    logic              done_q, fail_q;
    logic [LW-1:0]     dlen_q;

    logic [1:0]        rx_pair, metric;
    logic              avail, choice, tail_only, accept_start;
    logic [TW-1:0]     new_tally;

    assign busy         = (mode_q == SD_SEARCH);
    assign accept_start = start && !busy;
    assign depth_nx     = depth_q + DW'(1);
    assign tail_only    = (depth_q >= len_q - DW'(TAIL));
    assign new_tally    = tal_q[depth_q] + TW'(metric);

    sd_symbol_buf #(.DEPTH(MAX_SYM), .AW(DW)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (sym_valid && !busy),
        .wr_data (sym_bits),
        .clr     (accept_start),
        .rd_idx  (depth_q),
        .rd_data (rx_pair),
        .count   (buf_cnt)
    );

    sd_branch_unit u_branch (
        .cur_state (st_q[depth_q]),
        .rx_pair   (rx_pair),
        .tried     (tried_q[depth_q]),
        .tail_only (tail_only),
        .avail     (avail),
        .choice    (choice),
        .metric    (metric)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= SD_IDLE;
            depth_q <= '0;
            len_q   <= '0;
            dec_q   <= '0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
            dlen_q  <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                st_q[i]    <= '0;
                tal_q[i]   <= '0;
                tried_q[i] <= '0;
            end
        end else if (mode_q == SD_IDLE) begin
            if (accept_start) begin
                done_q  <= 1'b0;
                dlen_q  <= '0;
                dec_q   <= '0;
                depth_q <= '0;
                len_q   <= buf_cnt;
                for (int i = 0; i < SLOTS; i++) begin
                    st_q[i]    <= '0;
                    tal_q[i]   <= '0;
                    tried_q[i] <= '0;
                end
                if (buf_cnt <= DW'(TAIL)) begin
                    fail_q <= 1'b1;
                end else begin
                    fail_q <= 1'b0;
                    mode_q <= SD_SEARCH;
                end
            end
        end else begin
            if (!avail) begin
                if (depth_q == '0) begin
                    fail_q <= 1'b1;
                    mode_q <= SD_IDLE;
                end else begin
                    depth_q <= depth_q - DW'(1);
                end
            end else begin
                tried_q[depth_q][choice] <= 1'b1;
                if (new_tally < TW'(THR)) begin
                    dec_q[depth_q] <= choice;
                    if (depth_nx == len_q) begin
                        done_q <= 1'b1;
                        dlen_q <= LW'(len_q - DW'(TAIL));
                        mode_q <= SD_IDLE;
                    end else begin
                        depth_q           <= depth_nx;
                        st_q[depth_nx]    <= sd_next_state(st_q[depth_q], choice);
                        tal_q[depth_nx]   <= new_tally;
                        tried_q[depth_nx] <= '0;
                    end
                end
            end
        end
    end

    assign done     = done_q;
    assign fail     = fail_q;
    assign data_out = done_q ? dec_q[MAXD-1:0] : '0;
    assign data_len = dlen_q;

    // ---------------- assertions ----------------
    property p_tally_below;
        @(posedge clk) disable iff (rst) busy |-> (tal_q[depth_q] < TW'(THR));
    endproperty
    assert_tally_below_R3: assert property (p_tally_below)
        else $error("stored tally reached threshold");

    property p_one_step;
        @(posedge clk) disable iff (rst)
            busy |=> (!busy || depth_q == $past(depth_q) ||
                      depth_q == $past(depth_q) + DW'(1) ||
                      depth_q == $past(depth_q) - DW'(1));
    endproperty
    assert_one_step_R10: assert property (p_one_step)
        else $error("depth moved by more than one level");

    property p_root_zero;
        @(posedge clk) disable iff (rst) (busy && depth_q == '0) |-> (st_q[0] == 3'b000);
    endproperty
    assert_root_zero_R1: assert property (p_root_zero)
        else $error("root state not zero");

    property p_tail_zero;
        @(posedge clk) disable iff (rst)
            (busy && depth_q != '0 && (depth_q - DW'(1)) >= (len_q - DW'(TAIL)))
                |-> (st_q[depth_q][2] == 1'b0);
    endproperty
    assert_tail_zero_R5: assert property (p_tail_zero)
        else $error("input 1 taken in a tail level");

    property p_excl;
        @(posedge clk) disable iff (rst) !(done_q && fail_q);
    endproperty
    assert_done_fail_excl_R6: assert property (p_excl)
        else $error("done and fail both high");
endmodule

// File: tb/tb_sd_seq_decoder.sv
`timescale 1ns/1ps
module tb_sd_seq_decoder;
    logic        clk = 1'b0;
    logic        rst;
    logic        sym_valid;
    logic [1:0]  sym_bits;
    logic        start;
    logic        busy, done, fail;
    logic [12:0] data_out;
    logic [3:0]  data_len;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    sd_seq_decoder dut (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_bits(sym_bits),
        .start(start), .busy(busy), .done(done), .fail(fail),
        .data_out(data_out), .data_len(data_len)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // independent encoder following R1
    function automatic logic [1:0] enc_sym(inout logic [2:0] st, input logic u);
        logic [1:0] s;
        s  = {u ^ st[2] ^ st[1] ^ st[0], u ^ st[2] ^ st[0]};
        st = {u, st[2:1]};
        return s;
    endfunction

    task automatic push(input logic [1:0] s);
        sym_valid = 1'b1; sym_bits = s;
        @(negedge clk);
        sym_valid = 1'b0;
    endtask

    task automatic push_msg(input logic [12:0] msg, input int nd);
        logic [2:0] st;
        st = 3'b000;
        for (int i = 0; i < nd + 3; i++) begin
            logic u;
            u = (i < nd) ? msg[i] : 1'b0;
            push(enc_sym(st, u));
        end
    endtask

    task automatic run(output int cyc);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!(done || fail) && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic t_reset;
        check(busy == 0 && done == 0 && fail == 0, "R6 reset flags", {busy, done, fail}, 0);
        check(data_out == 0 && data_len == 0, "R7 reset data", data_out, 0);
    endtask

    task automatic t_example;
        int c;
        push(2'b01); push(2'b11); push(2'b01); push(2'b11);
        push(2'b01); push(2'b01); push(2'b11);
        run(c);
        check(done == 1 && fail == 0, "R8 done", {done, fail}, 2);
        check(data_out == 13'b1101, "R8 R2 R4 data", data_out, 13);
        check(data_len == 4, "R7 data_len", data_len, 4);
        check(c == 20, "R10 R4 backtrack cycles", c, 20);
    endtask

    task automatic t_clean_long;
        int c;
        push_msg(13'h1A5B, 13);
        run(c);
        check(done == 1, "R1 clean long done", done, 1);
        check(data_out == 13'h1A5B, "R1 R7 clean long data", data_out, 13'h1A5B);
        check(data_len == 13, "R7 len 13", data_len, 13);
        check(c == 16, "R10 clean cycles", c, 16);
    endtask

    task automatic t_clean_short;
        int c;
        push_msg(13'b110, 3);
        run(c);
        check(done == 1 && data_out == 13'b110, "R1 R2 short msg", data_out, 6);
        check(data_len == 3 && c == 6, "R10 short len/cycles", c, 6);
    endtask

    task automatic t_exhaust;
        int c;
        push(2'b10); push(2'b10); push(2'b10); push(2'b10);
        run(c);
        check(fail == 1 && done == 0, "R6 R3 exhausted", {done, fail}, 1);
        check(data_out == 0 && busy == 0, "R7 no data on fail", data_out, 0);
    endtask

    task automatic t_tail;
        int c;
        push(2'b11); push(2'b00); push(2'b10); push(2'b00);
        run(c);
        check(fail == 1 && done == 0, "R5 tail forces input 0", {done, fail}, 1);
    endtask

    task automatic t_short_frame;
        int c;
        push(2'b00); push(2'b00); push(2'b00);
        run(c);
        check(fail == 1 && c == 0, "R9 short frame fails at once", c, 0);
    endtask

    task automatic t_overflow;
        int c;
        push_msg(13'h0F0F, 13);
        push(2'b11); push(2'b01);
        run(c);
        check(done == 1 && data_out == 13'h0F0F, "R9 extra symbols ignored", data_out, 13'h0F0F);
    endtask

    task automatic t_busy_ignore;
        int c;
        push_msg(13'h0005, 4);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            sym_valid = 1'b1; sym_bits = 2'b11; start = 1'b1;
            @(negedge clk);
        end
        sym_valid = 1'b0; start = 1'b0;
        c = 0;
        while (!(done || fail) && c < 20000) begin @(negedge clk); c++; end
        check(done == 1 && data_out == 13'h0005, "R11 busy inputs ignored", data_out, 5);
        run(c);
        check(fail == 1 && c == 0, "R11 buffer empty after start", {done, fail}, 1);
    endtask

    initial begin
        rst = 1'b1; sym_valid = 1'b0; sym_bits = 2'b00; start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_example();
        t_clean_long();
        t_clean_short();
        t_exhaust();
        t_tail();
        t_short_frame();
        t_overflow();
        t_busy_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule